// File: doc/BRIEF.md
# T1 Transmit Payload Conditioner

This block sits in the transmit path of a T1 formatter, ahead of framing-bit generation, CRC and line coding. It takes the 193-bit frame one bit per strobe. Bit 0 of each frame is the framing bit, followed by 24 eight-bit channels, each sent most significant bit first. The block holds each channel for one byte time. It can then force a one into the seventh bit of any channel byte that is entirely zero. That bit is the second to last bit sent for the channel. Which channels are eligible for this stuffing is set either per channel or for all channels at once.

The same stage can insert a yellow alarm in one of two formats. The first clears the second bit of every channel. The second forces the framing-bit slot of every twelfth frame to one. A blue alarm override replaces the whole output, framing slots included, with ones. A channel strobe marks the bit period in which the least significant bit of each channel is being presented at the input. The block tracks its frame position by itself from reset. The first strobe after reset carries the framing bit of frame 0.

Top module: `t1_tx_cond`

## Requirements
- R1: While `rst` is high, and after it, until the first strobe, `ser_out` and `chclk` are 0. The first bit taken after reset is the framing bit of frame 0.
- R2: `ser_out` changes only on a clock where `bit_en` is high. After strobe k it carries the conditioned input bit of strobe k-8, and 0 for k < 8. Input positions within a frame: position 0 is the framing bit, and channel c (c = 0..23) takes positions 1+8c to 8+8c, most significant bit first.
- R3: With `zs_en` = 1 and `zs_global` = 1, every channel whose byte is all zero leaves with its seventh bit (byte bit 1, position 7+8c) set to 1. `zs_chan_en` is ignored.
- R4: With `zs_en` = 1 and `zs_global` = 0, only channels whose `zs_chan_en` bit is 1 are stuffed. Bit c enables channel c. Other zero channels pass unchanged.
- R5: With `zs_en` = 0, no stuffing happens and all channel bytes pass unchanged.
- R6: With `yel_en` = 1 and `yel_fmt` = 0, the second bit (byte bit 6) of every channel is sent as 0. The zero test for stuffing is made on the byte after that bit is cleared.
- R7: With `yel_en` = 1 and `yel_fmt` = 1, the framing slot of frame 11, counting frames from 0 at reset, is sent as 1. All other framing slots pass unchanged.
- R8: While `blue_en` is high at a strobe, `ser_out` becomes 1 after that strobe, framing slots included.
- R9: `chclk` is high for exactly the bit periods in which the input position is a channel LSB (8+8c). That gives 24 single-period pulses per frame and never two periods in a row.
- R10: The frame count wraps after 12 frames, so the frame-11 alarm slot of R7 recurs every 12 frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per T1 bit time |
| ser_in | input | 1 | Serial frame data, sampled on strobes |
| zs_en | input | 1 | Bit-7 zero suppression enable |
| zs_global | input | 1 | Stuff all zero channels, ignoring per-channel enables |
| zs_chan_en | input | 24 | Per-channel stuffing eligibility, bit c for channel c |
| yel_en | input | 1 | Yellow alarm insertion enable |
| yel_fmt | input | 1 | Yellow format: 0 clears bit 2, 1 sets the frame-11 framing slot |
| blue_en | input | 1 | Send unframed all ones |
| ser_out | output | 1 | Conditioned serial data, 8 strobes behind the input |
| chclk | output | 1 | High during input channel LSB periods |

## Verification
Some checks run on every cycle. The output and the channel strobe hold between bit strobes. A blue-alarm strobe produces a one. The channel strobe never lasts two bit periods. The position and frame counters stay in range. A byte loaded under global stuffing is never zero. A byte loaded under the bit-2 yellow format has that bit clear. Other behaviour only the bench scenarios can show: the exact eight-strobe alignment of each output bit, the choice between per-channel and global eligibility, the stuffing of bytes that yellow insertion empties, and the twelve-frame recurrence of the framing-slot alarm. The bench shows these by comparing whole multi-frame streams against a model written from the requirements.

// File: rtl/t1_tx_pkg.sv
package t1_tx_pkg;
  localparam int DEF_N_CH = 24;
  localparam int DEF_CH_W = 8;
  localparam int DEF_N_FR = 12;

  // True when frame position p carries the last bit of a channel.
  function automatic logic pos_is_lsb(int p, int ch_w);
    return (p != 0) && (((p - 1) % ch_w) == (ch_w - 1));
  endfunction
endpackage

// File: rtl/t1_frame_pos.sv
module t1_frame_pos
  import t1_tx_pkg::*;
#(
  parameter int N_CH = DEF_N_CH,
  parameter int CH_W = DEF_CH_W,
  parameter int N_FR = DEF_N_FR,
  localparam int FB = N_CH * CH_W + 1,
  localparam int PW = $clog2(FB),
  localparam int FW = $clog2(N_FR),
  localparam int CW = $clog2(N_CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [CW-1:0] chan,
  output logic          at_fbit,
  output logic          at_lsb,
  output logic          nxt_lsb,
  output logic          last_frm
);
  logic [PW-1:0] pos_q, pos_nxt;
  logic [FW-1:0] frm_q, frm_nxt;

  always_comb begin
    pos_nxt = (pos_q == PW'(FB - 1)) ? '0 : pos_q + 1'b1;
    frm_nxt = frm_q;
    if (pos_q == PW'(FB - 1))
      frm_nxt = (frm_q == FW'(N_FR - 1)) ? '0 : frm_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      frm_q <= '0;
    end else if (step) begin
      pos_q <= pos_nxt;
      frm_q <= frm_nxt;
    end
  end

  assign chan     = CW'((int'(pos_q) - 1) / CH_W);
  assign at_fbit  = (pos_q == '0);
  assign at_lsb   = pos_is_lsb(int'(pos_q), CH_W);
  assign nxt_lsb  = pos_is_lsb(int'(pos_nxt), CH_W);
  assign last_frm = (frm_q == FW'(N_FR - 1));

  // R10: position and frame counters never leave their ranges
  p_pos_range_r10: assert property (@(posedge clk) disable iff (rst)
    (int'(pos_q) < FB) && (int'(frm_q) < N_FR));
endmodule

// File: rtl/t1_byte_cond.sv
module t1_byte_cond
  import t1_tx_pkg::*;
#(
  parameter int N_CH = DEF_N_CH,
  parameter int CH_W = DEF_CH_W,
  localparam int CW = $clog2(N_CH),
  localparam int B2 = CH_W - 2,
  localparam int B7 = 1
) (
  input  logic [CH_W-1:0] byte_i,
  input  logic [CW-1:0]   chan,
  input  logic            zs_en,
  input  logic            zs_glb,
  input  logic [N_CH-1:0] zs_mask,
  input  logic            yel_b2,
  output logic [CH_W-1:0] byte_o
);
  logic [CH_W-1:0] masked;
  logic            elig;

  always_comb begin
    masked = byte_i;
    if (yel_b2) masked[B2] = 1'b0;
    elig   = zs_en && (zs_glb || zs_mask[chan]);
    byte_o = masked;
    if (elig && (masked == '0)) byte_o[B7] = 1'b1;
  end
endmodule

// File: rtl/t1_tx_cond.sv
module t1_tx_cond
  import t1_tx_pkg::*;
#(
  parameter int N_CH = DEF_N_CH,
  parameter int CH_W = DEF_CH_W,
  parameter int N_FR = DEF_N_FR
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic            ser_in,
  input  logic            zs_en,
  input  logic            zs_global,
  input  logic [N_CH-1:0] zs_chan_en,
  input  logic            yel_en,
  input  logic            yel_fmt,
  input  logic            blue_en,
  output logic            ser_out,
  output logic            chclk
);
  localparam int CW = $clog2(N_CH);

  logic [CW-1:0]   chan;
  logic            at_fbit, at_lsb, nxt_lsb, last_frm;
  logic [CH_W-1:0] d_q, shift, cond;

  t1_frame_pos #(.N_CH(N_CH), .CH_W(CH_W), .N_FR(N_FR)) u_pos (
    .clk(clk), .rst(rst), .step(bit_en), .chan(chan), .at_fbit(at_fbit),
    .at_lsb(at_lsb), .nxt_lsb(nxt_lsb), .last_frm(last_frm)
  );

  // Incoming bit joins the delay line; the framing slot of the last
  // frame in the count is forced high for the S-bit yellow format.
  always_comb begin
    shift = {d_q[CH_W-2:0], ser_in};
    if (at_fbit && yel_en && yel_fmt && last_frm) shift[0] = 1'b1;
  end

  t1_byte_cond #(.N_CH(N_CH), .CH_W(CH_W)) u_cond (
    .byte_i(shift), .chan(chan), .zs_en(zs_en), .zs_glb(zs_global),
    .zs_mask(zs_chan_en), .yel_b2(yel_en && !yel_fmt), .byte_o(cond)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q     <= '0;
      ser_out <= 1'b0;
      chclk   <= 1'b0;
    end else if (bit_en) begin
      d_q     <= at_lsb ? cond : shift;
      ser_out <= blue_en ? 1'b1 : d_q[CH_W-1];
      chclk   <= nxt_lsb;
    end
  end

  // R8: blue alarm yields a one on the following cycle
  p_blue_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_en && blue_en) |=> ser_out);

  // R2: outputs only move on bit strobes
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(ser_out) && $stable(chclk)));

  // R9: channel strobe never covers two consecutive bit periods
  p_chclk_single_r9: assert property (@(posedge clk) disable iff (rst)
    (bit_en && chclk) |=> !chclk);

  // R3: a byte loaded under global stuffing is never all zero
  p_glob_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_en && at_lsb && zs_en && zs_global) |=> (d_q != '0));

  // R6: a byte loaded under bit-2 yellow has that bit cleared
  p_yel_bit2_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_en && at_lsb && yel_en && !yel_fmt) |=> !d_q[CH_W-2]);
endmodule

// File: tb/t1_tx_cond_tb.sv
`timescale 1ns/1ps
module t1_tx_cond_tb;
  localparam int FB = 193;

  logic clk = 1'b0;
  logic rst, bit_en, ser_in, zs_en, zs_global, yel_en, yel_fmt, blue_en;
  logic [23:0] zs_chan_en;
  logic ser_out, chclk;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  t1_tx_cond u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in), .zs_en(zs_en),
    .zs_global(zs_global), .zs_chan_en(zs_chan_en), .yel_en(yel_en),
    .yel_fmt(yel_fmt), .blue_en(blue_en), .ser_out(ser_out), .chclk(chclk)
  );

  task automatic check(bit ok, string req, int act, int exp, int k);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s strobe %0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_in(int pat, int f, int c);
    if (pat == 0) return 8'h00;
    if (c == 5) return 8'h00;
    if (c == 3) return 8'h40;
    if (((f + c) % 4) == 0) return 8'h00;
    return 8'(c * 37 + f * 11 + 3);
  endfunction

  function automatic logic in_bit(int pat, int j);
    int f = j / FB;
    int p = j % FB;
    logic [7:0] v;
    if (p == 0) return ((f % 3) == 0);
    v = byte_in(pat, f, (p - 1) / 8);
    return v[7 - ((p - 1) % 8)];
  endfunction

  function automatic logic exp_bit(int pat, int j);
    int f = j / FB;
    int p = j % FB;
    int c;
    logic [7:0] v;
    if (p == 0) begin
      if (yel_en && yel_fmt && ((f % 12) == 11)) return 1'b1;
      return ((f % 3) == 0);
    end
    c = (p - 1) / 8;
    v = byte_in(pat, f, c);
    if (yel_en && !yel_fmt) v[6] = 1'b0;
    if (zs_en && (zs_global || zs_chan_en[c]) && (v == 8'h00)) v[1] = 1'b1;
    return v[7 - ((p - 1) % 8)];
  endfunction

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0; ser_in = 1'b0;
    repeat (3) @(negedge clk);
    check(ser_out == 1'b0, "R1", int'(ser_out), 0, -1);
    check(chclk == 1'b0, "R1", int'(chclk), 0, -1);
    rst = 1'b0;
  endtask

  task automatic run(int pat, int frames, string req);
    for (int k = 0; k < frames * FB; k++) begin
      int p;
      logic e;
      string r;
      @(negedge clk);
      ser_in = in_bit(pat, k);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      r = req;
      if (blue_en) e = 1'b1;
      else if (k < 8) e = 1'b0;
      else begin
        e = exp_bit(pat, k - 8);
        if (req == "R7" && (k - 8) >= 12 * FB) r = "R10";
        if (k < 16) r = "R2";
      end
      check(ser_out === e, r, int'(ser_out), int'(e), k);
      p = (k + 1) % FB;
      e = (p != 0) && (((p - 1) % 8) == 7);
      check(chclk === e, "R9", int'(chclk), int'(e), k);
    end
  endtask

  task automatic set_cfg(logic ze, logic zg, logic [23:0] m, logic ye,
                         logic yf, logic be);
    zs_en = ze; zs_global = zg; zs_chan_en = m;
    yel_en = ye; yel_fmt = yf; blue_en = be;
  endtask

  // R5: suppression off, zero bytes pass untouched
  task automatic t_pass();
    set_cfg(1'b0, 1'b1, 24'hFFFFFF, 1'b0, 1'b0, 1'b0);
    do_reset();
    run(1, 13, "R5");
  endtask

  // R4: per-channel eligibility only
  task automatic t_chan();
    set_cfg(1'b1, 1'b0, 24'hA5A5A5, 1'b0, 1'b0, 1'b0);
    do_reset();
    run(1, 13, "R4");
  endtask

  // R3: global stuffing overrides the per-channel enables
  task automatic t_glob();
    set_cfg(1'b1, 1'b1, 24'h000000, 1'b0, 1'b0, 1'b0);
    do_reset();
    run(0, 2, "R3");
    do_reset();
    run(1, 13, "R3");
  endtask

  // R6: bit-2 yellow, stuffing judged after the clear
  task automatic t_yel_b2();
    set_cfg(1'b1, 1'b0, 24'h000008, 1'b1, 1'b0, 1'b0);
    do_reset();
    run(1, 13, "R6");
  endtask

  // R7 and R10: framing-slot yellow recurs every 12 frames
  task automatic t_yel_s();
    set_cfg(1'b0, 1'b0, 24'h000000, 1'b1, 1'b1, 1'b0);
    do_reset();
    run(1, 25, "R7");
  endtask

  // R8: blue alarm sends all ones
  task automatic t_blue();
    set_cfg(1'b1, 1'b1, 24'hFFFFFF, 1'b1, 1'b0, 1'b1);
    do_reset();
    run(1, 3, "R8");
  endtask

  initial begin
    set_cfg(1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 1'b0);
    t_pass();
    t_chan();
    t_glob();
    t_yel_b2();
    t_yel_s();
    t_blue();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule